// File: doc/BRIEF.md
# Stereo Audio Sample FIFO and Interrupt Unit

This unit sits between a processor-side register bus and the serial shifter of a stereo audio port. It holds one sample queue for playback and one for capture, each 16 entries of 32 bits. Each entry carries one stereo pair, with the left sample in bits 15:0 and the right sample in bits 31:16. The unit passes this word through unchanged.

The unit compares both queue levels against thresholds that software programs, and raises service requests from the result. It latches capture overrun and playback underrun in flags that hold until software clears them. It folds the status bits, filtered by per-source mask bits, into a single interrupt line. Software writes playback samples and reads capture samples at one shared data address. A flush bit in the control register empties both queues.

The shifter takes playback samples over a valid/ready stream. `tx_valid` is high whenever the link is enabled. When the queue is empty the stream still completes a transfer, but it carries a zero sample and records an underrun.

Capture samples arrive over a second valid/ready stream. `rx_ready` follows the link enable and does not depend on the queue level, so the shifter never sees back-pressure. A sample accepted while the capture queue is full is discarded and records an overrun.

Top module: `audio_fifo_unit`

## Requirements
- R1: After reset the control and mask registers read 0, both queues are empty, both flags are clear, `irq` is 0, and the status register reads 0x99.
- R2: The bus uses word addresses: 0 control, 1 status, 2 mask, 3 clear, 4 data. The clear register and addresses 5 to 7 read 0. A write to address 4 appends to the playback queue, and that write is dropped when the queue holds 16 entries. A read of address 4 returns the oldest capture entry and removes it. When the capture queue is empty, that read returns 0 and removes nothing.
- R3: `tx_valid` equals the link enable. `tx_data` is the oldest playback entry, or 0 when the queue is empty. A cycle with `tx_valid` and `tx_ready` both high removes that entry.
- R4: `rx_ready` equals the link enable. A sample taken while `rx_ready` is low is ignored. A sample accepted while the capture queue holds 16 entries is discarded and sets the overrun flag.
- R5: The overrun flag (status bit 6) and the underrun flag (status bit 5) stay set until software writes 1 to the same bit position of the clear register. The underrun flag is set by a transfer that completes on the playback stream while that queue is empty. If a flag is set and cleared in the same cycle, the set wins.
- R6: Status bit 4 is 1 when the capture level is at or above control bits 15:12. Status bit 3 is 1 when the playback level is at or below control bits 11:8.
- R7: Status bit 7 is the inverse of the link enable (control bit 0). Bit 2 follows the `frame_busy` input. Bit 1 is 1 when the capture queue is not empty. Bit 0 is 1 when the playback queue is not full.
- R8: Writing control with bit 3 set empties both queues and clears both flags in the same cycle. Bit 3 always reads 0. The threshold and enable fields from that same write are kept.
- R9: `irq` is the OR of status bits 6 to 3, each gated by mask bits 6 to 3 at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the capture queue at address 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_valid | output | 1 | Playback sample offered |
| tx_ready | input | 1 | Shifter takes the playback sample |
| tx_data | output | 32 | Playback stereo pair |
| rx_valid | input | 1 | Capture sample offered by the shifter |
| rx_ready | output | 1 | Capture sample accepted |
| rx_data | input | 32 | Capture stereo pair |
| frame_busy | input | 1 | Shifter is moving a frame |
| irq | output | 1 | Masked interrupt |

## Verification
The in-line assertions check the following on every cycle:
- the level bound of each queue and the emptying done by a flush;
- that each flag holds until cleared, and rises only for a cause;
- that a full capture push always records an overrun and an empty playback transfer always records an underrun;
- that a capture queue with its stream closed does not move;
- that `irq` stays low while nothing is unmasked.

Only the bench's scenarios can show the following:
- the threshold comparisons across every level from 0 to 16 against every threshold from 0 to 15;
- the first-in first-out order of both queues;
- the rule that a set beats a same-cycle clear;
- register readback and the exact status encoding.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  // register word addresses
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;

  // control fields
  localparam int C_RXTH_LSB = 12;
  localparam int C_TXTH_LSB = 8;
  localparam int C_FLUSH    = 3;
  localparam int C_EN       = 0;
  localparam int TH_W       = 4;

  // status bit positions (mask and clear share them)
  localparam int S_OFF  = 7;
  localparam int S_OVR  = 6;
  localparam int S_UDR  = 5;
  localparam int S_RSRV = 4;
  localparam int S_TSRV = 3;
  localparam int S_BUSY = 2;
  localparam int S_RNE  = 1;
  localparam int S_TNF  = 0;

  // sticky flag indices
  localparam int F_OVR = 0;
  localparam int F_UDR = 1;
  localparam int N_FLAGS = 2;
endpackage

// File: rtl/afu_sample_fifo.sv
module afu_sample_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2: the level never passes the depth
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R2: a pop on an empty queue with no push leaves it empty
  assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (level == '0));
  // R8: a flush empties the queue
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/afu_event_flags.sv
module afu_event_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag[i] <= 1'b0;
      else if (flush)     flag[i] <= 1'b0;
      else if (set_ev[i]) flag[i] <= 1'b1;
      else if (clr_ev[i]) flag[i] <= 1'b0;
    end

    // R5: a set flag holds unless cleared or flushed
    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr_ev[i] && !flush) |=> flag[i]);
    // R5: a flag rises only after its event
    assert_set_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(set_ev[i]));
  end
endmodule

// File: rtl/audio_fifo_unit.sv
module audio_fifo_unit
  import audio_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              frame_busy,
  output logic              irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [TH_W-1:0] rx_th, tx_th;
  logic            link_en;
  logic [3:0]      mask_q;          // mask bits 6:3
  logic            wr_ctrl, wr_mask, wr_clr, wr_data, rd_data;
  logic            flush;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [LW-1:0]   tx_level, rx_level;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic            tx_pop, rx_push;
  logic [N_FLAGS-1:0] set_ev, clr_ev, flag;
  logic [7:0]      stat;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(A_CLR));
  assign wr_data = bus_wr && (bus_addr == ADDR_W'(A_DATA));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(A_DATA));
  assign flush   = wr_ctrl && bus_wdata[C_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_th   <= '0;
      tx_th   <= '0;
      link_en <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_th   <= bus_wdata[C_RXTH_LSB +: TH_W];
        tx_th   <= bus_wdata[C_TXTH_LSB +: TH_W];
        link_en <= bus_wdata[C_EN];
      end
      if (wr_mask) mask_q <= bus_wdata[S_OVR:S_TSRV];
    end
  end

  // playback stream
  assign tx_valid = link_en;
  assign tx_pop   = tx_valid && tx_ready;
  assign tx_data  = tx_empty ? '0 : tx_head;

  // capture stream, no back-pressure beyond the link enable
  assign rx_ready = link_en;
  assign rx_push  = rx_valid && rx_ready;

  afu_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_data), .push_data(bus_wdata), .pop(tx_pop),
    .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty));

  afu_sample_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_push), .push_data(rx_data), .pop(rd_data),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty));

  always_comb begin
    set_ev        = '0;
    clr_ev        = '0;
    set_ev[F_OVR] = rx_push && rx_full;
    set_ev[F_UDR] = tx_pop && tx_empty;
    clr_ev[F_OVR] = wr_clr && bus_wdata[S_OVR];
    clr_ev[F_UDR] = wr_clr && bus_wdata[S_UDR];
  end

  afu_event_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_ev(set_ev), .clr_ev(clr_ev), .flag(flag));

  always_comb begin
    stat         = '0;
    stat[S_OFF]  = !link_en;
    stat[S_OVR]  = flag[F_OVR];
    stat[S_UDR]  = flag[F_UDR];
    stat[S_RSRV] = rx_level >= LW'(rx_th);
    stat[S_TSRV] = tx_level <= LW'(tx_th);
    stat[S_BUSY] = frame_busy;
    stat[S_RNE]  = !rx_empty;
    stat[S_TNF]  = !tx_full;
  end

  assign irq = |(stat[S_OVR:S_TSRV] & mask_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): begin
        bus_rdata[C_RXTH_LSB +: TH_W] = rx_th;
        bus_rdata[C_TXTH_LSB +: TH_W] = tx_th;
        bus_rdata[C_EN]               = link_en;
      end
      ADDR_W'(A_STAT): bus_rdata = DATA_W'(stat);
      ADDR_W'(A_MASK): bus_rdata[S_OVR:S_TSRV] = mask_q;
      ADDR_W'(A_DATA): bus_rdata = rx_empty ? '0 : rx_head;
      default:         bus_rdata = '0;
    endcase
  end

  // R5: a transfer from an empty playback queue records an underrun
  assert_udr_on_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_empty && !flush) |=> flag[F_UDR]);
  // R4: an accepted sample into a full capture queue records an overrun
  assert_ovr_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_full && !flush) |=> flag[F_OVR]);
  // R4: with the capture stream closed the queue only moves by bus pops
  assert_closed_rx_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !rd_data && !flush) |=> $stable(rx_level));
  // R9: nothing unmasked keeps the interrupt low
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/audio_fifo_unit_bench.sv
`timescale 1ns/1ps
module audio_fifo_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic        frame_busy = 1'b0, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  audio_fifo_unit u_audio_fifo_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .frame_busy(frame_busy), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic [31:0] d);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 d = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic logic [31:0] tx_pat(int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] rx_pat(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0000_0107;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'd1, v); chk(v == 32'h99, "R1 status", v, 32'h99);
    rd(3'd0, v); chk(v == 0, "R1 control", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 mask", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(tx_valid == 0, "R3 tx_valid off", 32'(tx_valid), 0);
    chk(rx_ready == 0, "R4 rx_ready off", 32'(rx_ready), 0);

    // R2 unused addresses and clear register read 0
    for (int a = 3; a < 8; a++) begin
      if (a == 4) continue;
      rd(3'(a), v); chk(v == 0, "R2 unused read", v, 0);
    end

    // R7 link enable and off bit
    wr(3'd0, 32'h1);
    rd(3'd1, v); chk(v[7] == 0, "R7 off bit", v, 0);
    chk(tx_valid == 1, "R3 tx_valid on", 32'(tx_valid), 1);

    // R6 and R2: playback level 0..16 against every threshold
    for (int lvl = 0; lvl <= 16; lvl++) begin
      for (int th = 0; th < 16; th++) begin
        wr(3'd0, 32'(th << 8) | 32'h1);
        rd(3'd1, v);
        chk(v[3] == (lvl <= th), "R6 tx service", v, 32'(lvl <= th));
      end
      chk(v[0] == (lvl < 16), "R7 tx not full", v, 32'(lvl < 16));
      wr(3'd4, tx_pat(lvl));   // the 17th write is dropped (R2)
    end

    // R3 order of the playback queue, then an underrun
    for (int i = 0; i < 16; i++) begin
      tx_take(v); chk(v == tx_pat(i), "R3 tx order", v, tx_pat(i));
    end
    rd(3'd1, v); chk(v[5] == 0, "R5 no underrun yet", v, 0);
    tx_take(v); chk(v == 0, "R3 zero on empty", v, 0);
    rd(3'd1, v); chk(v[5] == 1, "R5 underrun set", v, 32'h20);
    rd(3'd1, v); chk(v[5] == 1, "R5 underrun sticky", v, 32'h20);

    // R9 per-source interrupt: rx th 4, tx th 0, both queues empty, underrun set
    wr(3'd0, 32'h4001);
    for (int b = 3; b <= 6; b++) begin
      logic expi;
      expi = (b == 3) || (b == 5);
      wr(3'd2, 32'(1 << b));
      chk(irq == expi, "R9 irq source", 32'(irq), 32'(expi));
      rd(3'd2, v); chk(v == 32'(1 << b), "R2 mask readback", v, 32'(1 << b));
    end
    wr(3'd2, 32'h20);
    wr(3'd3, 32'h20);
    rd(3'd1, v); chk(v[5] == 0, "R5 underrun cleared", v, 0);
    chk(irq == 0, "R9 irq after clear", 32'(irq), 0);
    wr(3'd2, 32'h0);

    // R6 and R4: capture level 0..16 against every threshold
    for (int lvl = 0; lvl <= 16; lvl++) begin
      for (int th = 0; th < 16; th++) begin
        wr(3'd0, 32'(th << 12) | 32'h1);
        rd(3'd1, v);
        chk(v[4] == (lvl >= th), "R6 rx service", v, 32'(lvl >= th));
      end
      chk(v[1] == (lvl > 0), "R7 rx not empty", v, 32'(lvl > 0));
      chk(v[6] == 0, "R4 no overrun before full", v, 0);
      rx_push(rx_pat(lvl));    // the 17th push overruns
    end
    rd(3'd1, v); chk(v[6] == 1, "R4 overrun on full", v, 32'h40);
    rd(3'd1, v); chk(v[6] == 1, "R5 overrun sticky", v, 32'h40);
    wr(3'd3, 32'h40);
    rd(3'd1, v); chk(v[6] == 0, "R5 overrun cleared", v, 0);

    // R5 set beats clear in the same cycle
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 32'hDEAD_BEEF;
    bus_addr = 3'd3; bus_wdata = 32'h40; bus_wr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr = 1'b0;
    rd(3'd1, v); chk(v[6] == 1, "R5 set wins", v, 32'h40);
    wr(3'd3, 32'h40);

    // R2 capture order, then empty read
    for (int i = 0; i < 16; i++) begin
      rd(3'd4, v); chk(v == rx_pat(i), "R2 rx order", v, rx_pat(i));
    end
    rd(3'd4, v); chk(v == 0, "R2 empty read", v, 0);
    rd(3'd1, v); chk(v[1] == 0, "R2 rx drained", v, 0);

    // R8 flush with fields kept
    wr(3'd4, 32'h1111_2222); wr(3'd4, 32'h3333_4444);
    rx_push(32'h7777_8888);
    tx_take(v);
    tx_take(v);
    tx_take(v);              // underrun
    rx_push(32'h1); wr(3'd0, 32'h1);
    wr(3'd4, 32'h5555_6666);
    wr(3'd0, 32'h5209);
    rd(3'd0, v); chk(v == 32'h5201, "R8 control kept", v, 32'h5201);
    rd(3'd1, v); chk(v == 32'h09, "R8 status after flush", v, 32'h09);
    rd(3'd4, v); chk(v == 0, "R8 rx emptied", v, 0);
    #1 chk(tx_data == 0, "R8 tx emptied", tx_data, 0);

    // R4 link off: stream ignored, R7 busy
    wr(3'd0, 32'h0);
    chk(rx_ready == 0, "R4 rx_ready follows enable", 32'(rx_ready), 0);
    rx_push(32'hABCD_0123);
    tx_take(v);
    rd(3'd1, v); chk(v == 32'h99, "R4 ignored when off", v, 32'h99);
    frame_busy = 1'b1;
    rd(3'd1, v); chk(v == 32'h9D, "R7 busy", v, 32'h9D);
    frame_busy = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule